// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block paces a small processor core. It splits the system clock into four phases, T1 to T4, so that one instruction cycle lasts four system clocks. It keeps the core in a two-stage overlap: the word at the current program counter is fetched while the word fetched one cycle earlier executes. It also holds the core idle for a fixed start-up interval after reset and again after a wake event that ends a halt.

The program counter moves only on the T4 to T1 boundary. The taken-branch flag and its target are sampled at that edge. When the executing slot takes a branch, the word already fetched behind it is dropped. The next cycle then fetches the target while its execute slot runs empty, so the branch costs two instruction cycles in total. A halt request seen at the same edge stops the phases and all fetching. Decoding, arithmetic and memories sit outside the block.

The controller is a three-state machine:
- `ST_BOOT` is the start-up wait. It moves to `ST_RUN` when the start-up count expires.
- `ST_RUN` cycles through the phases. It moves to `ST_IDLE` on a halt request at the end of T4.
- `ST_IDLE` is the halted state. It moves back to `ST_BOOT` when a wake event arrives.
- Reset from any state goes to `ST_BOOT`.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows all phase strobes low, `fetch_en` low, `exec_valid` low and `fetch_addr` equal to 0.
- R2: After reset is released, exactly `BOOT_CLKS` clocks pass with every phase strobe low, and then T1 appears.
- R3: `phase_stb` is one-hot or zero. Bit 0 is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4. The strobes step T1, T2, T3, T4 and back to T1. The strobes may go to zero only after T4, and they restart only at T1.
- R4: `fetch_en` equals the T1 strobe. `fetch_addr` and `exec_valid` stay constant through T2, T3 and T4 of a cycle.
- R5: With no branch taken, each instruction cycle fetches the previous fetch address plus 1, modulo 2^`PC_W`, and `exec_valid` is high.
- R6: The first instruction cycle after a start-up wait has `exec_valid` low.
- R7: When `br_taken` is high in T4 and `exec_valid` is high, the next cycle fetches `br_target` with `exec_valid` low. The cycle after that fetches `br_target`+1 with `exec_valid` high.
- R8: `br_taken` has no effect when it is high in T1, T2 or T3, or when `exec_valid` is low.
- R9: `exec_en` pulses during T4 exactly when `exec_valid` is high, and it is low at all other times.
- R10: `halt_req` high in T4 stops the strobes and `fetch_en` from the next clock on, and `fetch_addr` then holds. `halt_req` in T1, T2 or T3 has no effect.
- R11: A `wake` pulse while halted restarts the wait, so exactly `BOOT_CLKS` clocks pass with the strobes low. The core then resumes by fetching the held address with `exec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request, sampled at the end of T4 |
| wake | input | 1 | Wake event, acted on while halted |
| br_taken | input | 1 | The executing instruction changes the program counter |
| br_target | input | PC_W | New program counter value |
| phase_stb | output | 4 | Phase strobes, one-hot (bit 0 = T1) |
| fetch_addr | output | PC_W | Address of the word being fetched |
| fetch_en | output | 1 | Fetch strobe, high in T1 |
| exec_en | output | 1 | Commit strobe, high in T4 of a valid slot |
| exec_valid | output | 1 | The executing slot holds a real instruction |

## Verification
The bench counts the start-up clocks after reset and after wake to the exact value. A timer that is one clock off, or that skips the restart on wake, shows up as a wrong count.

It follows a taken branch with a second branch request in the empty slot, and it raises branch and halt requests in phases other than T4. A design that acts in the bubble, or samples outside T4, fetches the wrong address or stops early.

A branch just below the top of the address space checks the wrap to zero. The held address after a halt checks that the core resumes at the word whose fetch was lost.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_IDLE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/iseq_phase_ring.sv
module iseq_phase_ring #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    output logic [NPH-1:0] strobe,
    output logic           last
);
    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ph_q <= '0;
        end else if (ph_q == PW'(NPH - 1)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PW'(1);
        end
    end

    assign last = active && (ph_q == PW'(NPH - 1));

    generate
        for (genvar i = 0; i < NPH; i++) begin : g_stb
            assign strobe[i] = active && (ph_q == PW'(i));
        end
    endgenerate

    // R3: inside a cycle the strobe moves up one phase each clock
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> (strobe == ($past(strobe) << 1)));

    // R3: after the last phase the ring either restarts at T1 or goes quiet
    a_r3_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        last |=> (strobe == '0 || strobe == NPH'(1)));

endmodule

// File: rtl/iseq_boot_timer.sv
module iseq_boot_timer #(
    parameter int CLKS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic counting,
    output logic done
);
    localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (counting && !done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = counting && (cnt_q == CW'(CLKS - 1));

    // R2: the count climbs by one on every clock of the wait
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (counting && !done && !restart) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R11: a restart always begins a fresh wait from zero
    a_r11_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/iseq_pc_track.sv
module iseq_pc_track #(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            hold,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] pc,
    output logic            valid
);
    logic take;

    assign take = br_taken && valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            valid <= 1'b0;
        end else if (advance) begin
            if (take) begin
                pc    <= br_target;
                valid <= 1'b0;
            end else if (hold) begin
                valid <= 1'b0;
            end else begin
                pc    <= pc + PC_W'(1);
                valid <= 1'b1;
            end
        end
    end

    // R7: a taken branch empties the following execute slot
    a_r7_flush: assert property (@(posedge clk) disable iff (rst)
        (advance && take) |=> (!valid && pc == $past(br_target)));

    // R5: a plain boundary moves the fetch address up by one
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (advance && !take && !hold) |=> (valid && pc == $past(pc) + PC_W'(1)));

    // R4: nothing moves away from a boundary
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(pc) && $stable(valid)));

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import iseq_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int BOOT_CLKS = 1024
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  halt_req,
    input  logic                  wake,
    input  logic                  br_taken,
    input  logic [PC_W-1:0]       br_target,
    output logic [NUM_PHASES-1:0] phase_stb,
    output logic [PC_W-1:0]       fetch_addr,
    output logic                  fetch_en,
    output logic                  exec_en,
    output logic                  exec_valid
);
    seq_state_e state_q, state_d;

    logic                  active;
    logic                  last;
    logic                  boot_done;
    logic                  boot_restart;
    logic                  advance;
    logic [NUM_PHASES-1:0] strobe;
    logic [PC_W-1:0]       pc;
    logic                  valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (boot_done)         state_d = ST_RUN;
            ST_RUN:  if (last && halt_req)  state_d = ST_IDLE;
            ST_IDLE: if (wake)              state_d = ST_BOOT;
            default:                        state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        active       = (state_q == ST_RUN);
        advance      = active && last;
        boot_restart = (state_q == ST_IDLE) && wake;
        phase_stb    = strobe;
        fetch_en     = strobe[0];
        exec_en      = strobe[NUM_PHASES-1] && valid;
        fetch_addr   = pc;
        exec_valid   = valid;
    end

    iseq_phase_ring #(.NPH(NUM_PHASES)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .strobe (strobe),
        .last   (last)
    );

    iseq_boot_timer #(.CLKS(BOOT_CLKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (boot_restart),
        .counting (state_q == ST_BOOT),
        .done     (boot_done)
    );

    iseq_pc_track #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .hold      (halt_req),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pc        (pc),
        .valid     (valid)
    );

    // R1: reset leaves the block quiet at address zero
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (phase_stb == '0 && !fetch_en && !exec_valid && fetch_addr == '0));

    // R2: no fetch during the start-up wait
    a_r2_boot_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT) |-> (phase_stb == '0 && !fetch_en));

    // R10: a halt at the end of T4 silences the strobes on the next clock
    a_r10_halt_stops: assert property (@(posedge clk) disable iff (rst)
        (advance && halt_req) |=> (phase_stb == '0 && !fetch_en && !exec_en));

    // R10: the fetch address is frozen while halted
    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !wake) |=> $stable(fetch_addr));

    // R6: the first cycle after start-up carries no instruction
    a_r6_first_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT && boot_done) |=> !exec_valid);

    // R11: a wake while halted goes back to the start-up wait
    a_r11_wake_boot: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && wake) |=> (state_q == ST_BOOT));

endmodule

// File: tb/instr_sequencer_bench.sv
module instr_sequencer_bench;
    localparam int PC_W = 12;
    localparam int BOOT = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst = 1'b1;
    logic            halt_req = 1'b0;
    logic            wake = 1'b0;
    logic            br_taken = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic [3:0]      phase_stb;
    logic [PC_W-1:0] fetch_addr;
    logic            fetch_en;
    logic            exec_en;
    logic            exec_valid;

    instr_sequencer #(.PC_W(PC_W), .BOOT_CLKS(BOOT)) u_instr_sequencer (
        .clk        (clk),
        .rst        (rst),
        .halt_req   (halt_req),
        .wake       (wake),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .phase_stb  (phase_stb),
        .fetch_addr (fetch_addr),
        .fetch_en   (fetch_en),
        .exec_en    (exec_en),
        .exec_valid (exec_valid)
    );

    typedef struct packed {
        logic [PC_W-1:0] addr;
        logic            valid;
    } slot_t;

    slot_t           exp_q[$];
    slot_t           mon_e;
    logic [PC_W-1:0] m_pc = '0;
    logic            m_valid = 1'b0;
    logic [PC_W-1:0] cur_addr = '0;
    logic            cur_valid = 1'b0;
    logic [3:0]      prev_ph = '0;
    int              total = 0;
    int              bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: samples on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            check(phase_stb == 4'b0 && !fetch_en && !exec_valid && fetch_addr == '0,
                  "R1", "reset outputs", {phase_stb, fetch_en, exec_valid}, 0);
        end else begin
            check($countones(phase_stb) <= 1, "R3", "one-hot", phase_stb, 1);
            if (prev_ph != 4'b0 && phase_stb != 4'b0)
                check(phase_stb == {prev_ph[2:0], prev_ph[3]}, "R3", "phase order",
                      phase_stb, {prev_ph[2:0], prev_ph[3]});
            if (prev_ph == 4'b0 && phase_stb != 4'b0)
                check(phase_stb == 4'b0001, "R3", "restart at T1", phase_stb, 1);
            if (prev_ph != 4'b0 && prev_ph != 4'b1000 && phase_stb == 4'b0)
                check(1'b0, "R3", "stopped mid-cycle", prev_ph, 8);
            check(fetch_en == phase_stb[0], "R4", "fetch_en vs T1", fetch_en, phase_stb[0]);
            if (phase_stb[0]) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected fetch", fetch_addr, -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(fetch_addr == mon_e.addr, "R5/R7/R11", "fetch address",
                          fetch_addr, mon_e.addr);
                    check(exec_valid == mon_e.valid, "R6/R7/R8", "exec_valid",
                          exec_valid, mon_e.valid);
                    cur_addr  = mon_e.addr;
                    cur_valid = mon_e.valid;
                end
            end else if (phase_stb != 4'b0) begin
                check(fetch_addr == cur_addr && exec_valid == cur_valid, "R4",
                      "mid-cycle stability", fetch_addr, cur_addr);
            end
            if (phase_stb[3])
                check(exec_en == cur_valid, "R9", "exec_en in T4", exec_en, cur_valid);
            else
                check(!exec_en, "R9", "exec_en outside T4", exec_en, 0);
        end
        prev_ph <= phase_stb;
    end

    // driver: one instruction cycle, entered just after the edge that starts T1
    task automatic instr(input bit br, input logic [PC_W-1:0] tgt, input int bph,
                         input bit hlt, input int hph);
        bit take;
        bit stop;
        exp_q.push_back({m_pc, m_valid});
        for (int k = 0; k < 4; k++) begin
            br_taken  = br && (bph == k);
            br_target = tgt;
            halt_req  = hlt && (hph == k);
            @(posedge clk); #1;
        end
        br_taken = 1'b0;
        halt_req = 1'b0;
        take = br && (bph == 3) && m_valid;
        stop = hlt && (hph == 3);
        if (take) begin
            m_pc    = tgt;
            m_valid = 1'b0;
        end else if (stop) begin
            m_valid = 1'b0;
        end else begin
            m_pc    = m_pc + PC_W'(1);
            m_valid = 1'b1;
        end
    endtask

    task automatic boot_wait(input string req);
        int n = 0;
        while (phase_stb == 4'b0 && n < BOOT + 10) begin
            @(posedge clk); #1;
            n++;
        end
        check(n == BOOT, req, "start-up clocks", n, BOOT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_pc    = '0;
        m_valid = 1'b0;
        boot_wait("R2");

        // R6 then R5: empty first slot, then sequential fetches
        repeat (5) instr(1'b0, '0, 0, 1'b0, 0);

        // R7: taken branch, then R8: branch request in the bubble is ignored
        instr(1'b1, 12'h100, 3, 1'b0, 0);
        instr(1'b1, 12'h200, 3, 1'b0, 0);
        repeat (2) instr(1'b0, '0, 0, 1'b0, 0);

        // R8: branch flag outside T4 is ignored
        instr(1'b1, 12'h300, 1, 1'b0, 0);
        instr(1'b1, 12'h340, 0, 1'b0, 0);
        instr(1'b0, '0, 0, 1'b0, 0);

        // R5: address wraps past the top
        instr(1'b1, 12'hFFE, 3, 1'b0, 0);
        repeat (4) instr(1'b0, '0, 0, 1'b0, 0);

        // R10: halt outside T4 is ignored
        instr(1'b0, '0, 0, 1'b1, 2);
        instr(1'b0, '0, 0, 1'b0, 0);

        // R10: halt at T4
        instr(1'b0, '0, 0, 1'b1, 3);
        held = m_pc;
        for (int i = 0; i < 6; i++) begin
            br_taken  = i[0];
            br_target = 12'h055;
            @(posedge clk); #1;
            check(phase_stb == 4'b0 && !fetch_en, "R10", "halted strobes",
                  {phase_stb, fetch_en}, 0);
            check(fetch_addr == held, "R10", "halted address", fetch_addr, held);
        end
        br_taken = 1'b0;

        // R11: wake restarts the wait and resumes at the held address
        wake = 1'b1;
        @(posedge clk); #1;
        wake = 1'b0;
        boot_wait("R11");
        repeat (3) instr(1'b0, '0, 0, 1'b0, 0);

        check(exp_q.size() == 0, "R5", "unconsumed expectations", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule